// File: doc/BRIEF.md
# Protected clock-source select register

This block is one 8-bit control register inside a clock and power management unit. Its bits choose the sources for the core clock, the watchdog clock and the periodic tick timer, and say which clocks keep running in stop modes. Each bit drives a mux-select or enable pin directly. Software reads the register at any time. A write goes through only when the protection input is low. Once through, each bit is gated by its own permission, which depends on the operating mode and on a write-once lock.

The lock is a sticky flag. It is set by a single-cycle pulse that marks the first write to the watchdog configuration register, and it freezes the three watchdog-related bits in normal mode. Special mode ignores the lock. When the oscillator-valid input goes low, hardware clears the low watchdog-source bit. That clear arms a one-shot permission, so software may set the bit once more even while locked. The high watchdog-source bit is never touched by oscillator loss. The bus port is a plain single-cycle strobe with an address compare, so it has no back-pressure: every strobe resolves in the cycle it is seen. Software confirms which bits took effect by reading the register back.

Top module: `clk_src_sel_reg`

## Requirements
- R1: After reset the register reads 0x80, with bit 7 set and all other bits clear, and both the lock and the re-arm flag are clear.
- R2: `rd_data` always equals the stored register value, and each select output equals its bit: bit 7 core-from-PLL, 6 PLL-kept-in-stop, 5 watchdog-halt-in-stop, 4 watchdog-source-high, 3 tick-runs-in-stop, 2 watchdog-runs-in-stop, 1 tick-source, 0 watchdog-source-low.
- R3: A write strobe while `prot_on` is 1 changes no bit, in either mode.
- R4: A write strobe whose `bus_addr` differs from `REG_ADDR` changes no bit.
- R5: In special mode with protection off, a write loads all 8 bits, whether or not the lock is set.
- R6: In normal mode with protection off, bits 7, 6, 3, 2 and 1 take the written value on every write.
- R7: In normal mode, bits 5, 4 and 0 take the written value only while the lock is clear. The lock is set by a `wdog_cfg_first_wr` pulse and takes effect from the next cycle, so a write in the same cycle as the pulse still lands. Only reset clears the lock.
- R8: While `osc_valid` is 0, bit 0 is cleared on the next edge. Bit 4 is never changed by `osc_valid`.
- R9: A hardware clear of a set bit 0 arms a one-shot permission. The next accepted normal-mode write with data bit 0 = 1 sets bit 0 even when locked, and this uses up the permission. Any accepted write of bit 0 = 1 while `osc_valid` is 1 uses it up, in either mode.
- R10: When a hardware clear and a write of bit 0 = 1 meet in the same cycle, bit 0 ends up 0.
- R11: In one write, forbidden bits keep their values while permitted bits update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Stored register value |
| prot_on | input | 1 | 1 blocks all writes |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| wdog_cfg_first_wr | input | 1 | Pulse on the first watchdog configuration write |
| osc_valid | input | 1 | Oscillator clock is valid |
| sel_core_pll | output | 1 | Bit 7 |
| stop_pll_keep | output | 1 | Bit 6 |
| stop_wdog_halt | output | 1 | Bit 5 |
| wdog_src_hi | output | 1 | Bit 4 |
| stop_tick_run | output | 1 | Bit 3 |
| stop_wdog_run | output | 1 | Bit 2 |
| tick_src_osc | output | 1 | Bit 1 |
| wdog_src_lo | output | 1 | Bit 0 |

## Verification
The hardest state to reach is a locked register whose bit 0 was cleared by oscillator loss and whose one-shot permission is still unused. Getting there takes four steps in order: set bit 0 before the lock, raise the lock pulse, drop `osc_valid`, then write. The stimulus walks that path twice. The second time, special mode changes bit 0 behind the permission's back, and a further normal-mode write must then be refused. It also lines up an oscillator drop with a write of 1 in the same cycle. After the directed part, a random phase drives all inputs against the behavioural model.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int REG_W = 8;
  localparam int B_CORE_PLL   = 7;
  localparam int B_PLL_KEEP   = 6;
  localparam int B_WDOG_HALT  = 5;
  localparam int B_WDOG_HI    = 4;
  localparam int B_TICK_RUN   = 3;
  localparam int B_WDOG_RUN   = 2;
  localparam int B_TICK_SRC   = 1;
  localparam int B_WDOG_LO    = 0;
  localparam logic [REG_W-1:0] RST_VALUE = 8'h80;
  localparam logic [REG_W-1:0] FREE_MASK = (8'h1 << B_CORE_PLL) | (8'h1 << B_PLL_KEEP) |
                                           (8'h1 << B_TICK_RUN) | (8'h1 << B_WDOG_RUN) |
                                           (8'h1 << B_TICK_SRC);
  localparam logic [REG_W-1:0] ONCE_MASK = (8'h1 << B_WDOG_HALT) | (8'h1 << B_WDOG_HI) |
                                           (8'h1 << B_WDOG_LO);
  localparam logic [REG_W-1:0] HWCLR_MASK = 8'h1 << B_WDOG_LO;
endpackage

// File: rtl/ccs_wr_perm.sv
module ccs_wr_perm #(
  parameter int W = 8,
  parameter logic [W-1:0] FREE = '0,
  parameter logic [W-1:0] ONCE = '0,
  parameter int REARM_BIT = 0
) (
  input  logic         wr_hit,
  input  logic         special,
  input  logic         locked,
  input  logic         rearm,
  input  logic         rearm_data,
  output logic [W-1:0] mask
);
  localparam logic [W-1:0] REARM_VEC = {{(W-1){1'b0}}, 1'b1} << REARM_BIT;

  logic [W-1:0] normal_mask;

  always_comb begin
    normal_mask = FREE;
    if (!locked) normal_mask = normal_mask | ONCE;
    if (locked && rearm && rearm_data) normal_mask = normal_mask | REARM_VEC;
  end

  always_comb begin
    if (!wr_hit)      mask = '0;
    else if (special) mask = '1;
    else              mask = normal_mask;
  end
endmodule

// File: rtl/ccs_flag_track.sv
module ccs_flag_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_pulse,
  input  logic hw_clr_evt,
  input  logic rearm_use,
  output logic lock_q,
  output logic rearm_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      if (lock_pulse) lock_q <= 1'b1;
      if (hw_clr_evt)     rearm_q <= 1'b1;
      else if (rearm_use) rearm_q <= 1'b0;
    end
  end

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_rearm_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr_evt |=> rearm_q);
  p_rearm_used_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_q && rearm_use && !hw_clr_evt) |=> !rearm_q);
endmodule

// File: rtl/ccs_field_reg.sv
module ccs_field_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] CLR_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wdata,
  input  logic         clr_req,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_clr
      always_ff @(posedge clk) begin
        if (!rst_n)          q[i] <= RST_VAL[i];
        else if (clr_req)    q[i] <= 1'b0;
        else if (wr_mask[i]) q[i] <= wdata[i];
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)          q[i] <= RST_VAL[i];
        else if (wr_mask[i]) q[i] <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/clk_src_sel_reg.sv
module clk_src_sel_reg
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  rd_data,
  input  logic              prot_on,
  input  logic              special_mode,
  input  logic              wdog_cfg_first_wr,
  input  logic              osc_valid,
  output logic              sel_core_pll,
  output logic              stop_pll_keep,
  output logic              stop_wdog_halt,
  output logic              wdog_src_hi,
  output logic              stop_tick_run,
  output logic              stop_wdog_run,
  output logic              tick_src_osc,
  output logic              wdog_src_lo
);
  logic             wr_hit;
  logic [REG_W-1:0] wr_mask;
  logic [REG_W-1:0] reg_q;
  logic             lock_q, rearm_q;
  logic             hw_clr_evt, rearm_use;

  assign wr_hit     = bus_we && (bus_addr == REG_ADDR) && !prot_on;
  assign hw_clr_evt = !osc_valid && reg_q[B_WDOG_LO];
  assign rearm_use  = osc_valid && wr_mask[B_WDOG_LO] && bus_wdata[B_WDOG_LO];

  ccs_wr_perm #(.W(REG_W), .FREE(FREE_MASK), .ONCE(ONCE_MASK), .REARM_BIT(B_WDOG_LO)) perm_i (
    .wr_hit(wr_hit), .special(special_mode), .locked(lock_q), .rearm(rearm_q),
    .rearm_data(bus_wdata[B_WDOG_LO]), .mask(wr_mask));

  ccs_flag_track flags_i (
    .clk(clk), .rst_n(rst_n), .lock_pulse(wdog_cfg_first_wr), .hw_clr_evt(hw_clr_evt),
    .rearm_use(rearm_use), .lock_q(lock_q), .rearm_q(rearm_q));

  ccs_field_reg #(.W(REG_W), .RST_VAL(RST_VALUE), .CLR_MASK(HWCLR_MASK)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wdata(bus_wdata),
    .clr_req(!osc_valid), .q(reg_q));

  assign rd_data        = reg_q;
  assign sel_core_pll   = reg_q[B_CORE_PLL];
  assign stop_pll_keep  = reg_q[B_PLL_KEEP];
  assign stop_wdog_halt = reg_q[B_WDOG_HALT];
  assign wdog_src_hi    = reg_q[B_WDOG_HI];
  assign stop_tick_run  = reg_q[B_TICK_RUN];
  assign stop_wdog_run  = reg_q[B_WDOG_RUN];
  assign tick_src_osc   = reg_q[B_TICK_SRC];
  assign wdog_src_lo    = reg_q[B_WDOG_LO];

  p_prot_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && osc_valid) |=> rd_data == $past(rd_data));
  p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_valid |=> !rd_data[B_WDOG_LO]);
  p_hi_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_valid && !wr_hit) |=> rd_data[B_WDOG_HI] == $past(rd_data[B_WDOG_HI]));
  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !special_mode && lock_q && !rearm_q && osc_valid) |=>
      (rd_data & ONCE_MASK) == ($past(rd_data) & ONCE_MASK));
  p_free_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (rd_data & FREE_MASK) == ($past(bus_wdata) & FREE_MASK));
endmodule

// File: tb/clk_src_sel_reg_tb_top.sv
module clk_src_sel_reg_tb_top;
  localparam logic [7:0] A = 8'h12;
  logic clk = 0, rst_n = 0, we = 0, prot = 0, spec = 0, pulse = 0, osc = 1;
  logic [7:0] addr = 0, wdata = 0, rd;
  logic o7, o6, o5, o4, o3, o2, o1, o0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_src_sel_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .rd_data(rd), .prot_on(prot), .special_mode(spec), .wdog_cfg_first_wr(pulse),
    .osc_valid(osc), .sel_core_pll(o7), .stop_pll_keep(o6), .stop_wdog_halt(o5),
    .wdog_src_hi(o4), .stop_tick_run(o3), .stop_wdog_run(o2), .tick_src_osc(o1),
    .wdog_src_lo(o0));

  // behavioural reference
  logic [7:0] m_reg;
  bit m_lock, m_rearm;
  logic [7:0] nx;
  bit acc, ok, ok0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg <= 8'h80; m_lock <= 0; m_rearm <= 0;
    end else begin
      nx = m_reg;
      acc = we && (addr == A) && !prot;
      ok0 = 0;
      for (int b = 0; b < 8; b++) begin
        if (!acc) ok = 0;
        else if (spec) ok = 1;
        else if (b == 5 || b == 4) ok = !m_lock;
        else if (b == 0) ok = !m_lock || (m_rearm && wdata[0]);
        else ok = 1;
        if (ok) nx[b] = wdata[b];
        if (b == 0) ok0 = ok;
      end
      if (!osc) nx[0] = 0;
      if (!osc && m_reg[0]) m_rearm <= 1;
      else if (osc && ok0 && wdata[0]) m_rearm <= 0;
      if (pulse) m_lock <= 1;
      m_reg <= nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd !== m_reg) begin
        errors++;
        $display("FAIL R2 per-cycle rd_data actual %02h expected %02h", rd, m_reg);
      end
      checks++;
      if ({o7, o6, o5, o4, o3, o2, o1, o0} !== m_reg) begin
        errors++;
        $display("FAIL R2 select pins actual %02h expected %02h",
                 {o7, o6, o5, o4, o3, o2, o1, o0}, m_reg);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] exp);
    @(negedge clk);
    checks++;
    if (rd !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, rd, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit p = 0, input bit o = 1);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d; pulse = p; osc = o;
    @(posedge clk); #1;
    we = 0; pulse = 0; osc = 1;
  endtask

  task automatic osc_drop();
    @(posedge clk); #1 osc = 0;
    @(posedge clk); #1 osc = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset value", 8'h80);
    prot = 1;
    wr(A, 8'h3F);            chk("R3 protected normal", 8'h80);
    spec = 1; wr(A, 8'h00);  chk("R3 protected special", 8'h80);
    prot = 0; spec = 0;
    wr(A ^ 8'h01, 8'h00);    chk("R4 address miss", 8'h80);
    wr(A, 8'h7F);            chk("R7 unlocked write", 8'h7F);
    wr(A, 8'h31, 1);         chk("R7 write with lock pulse", 8'h31);
    wr(A, 8'hCE);            chk("R11 locked kept free set", 8'hFF);
    wr(A, 8'h00);            chk("R6 free bits cleared", 8'h31);
    osc_drop();              chk("R8 hw clear keeps bit4", 8'h30);
    wr(A, 8'h00);            chk("R9 zero write keeps rearm", 8'h30);
    wr(A, 8'h01);            chk("R9 rearm set", 8'h31);
    wr(A, 8'h00);            chk("R7 locked after rearm", 8'h31);
    osc_drop();              chk("R8 second clear", 8'h30);
    wr(A, 8'h01);            chk("R9 rearm set again", 8'h31);
    spec = 1; wr(A, 8'h30);  chk("R5 special after lock", 8'h30);
    spec = 0; wr(A, 8'h01);  chk("R9 rearm used up", 8'h30);
    spec = 1; wr(A, 8'h31); spec = 0;
    wr(A, 8'h01, 0, 0);      chk("R10 clear beats write", 8'h30);
    wr(A, 8'h01);            chk("R10 rearm after collision", 8'h31);
    spec = 1; wr(A, 8'h00);  chk("R5 special zero", 8'h00);
    wr(A, 8'hB5);            chk("R5 special pattern", 8'hB5);
    spec = 0;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      we = $urandom_range(0, 1); addr = ($urandom_range(0, 3) == 0) ? A ^ 8'h04 : A;
      wdata = 8'($urandom); prot = ($urandom_range(0, 5) == 0);
      spec = ($urandom_range(0, 4) == 0); pulse = ($urandom_range(0, 60) == 0);
      osc = ($urandom_range(0, 7) != 0);
    end
    @(posedge clk); #1 we = 0; pulse = 0; osc = 1; prot = 0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule